// File: doc/BRIEF.md
# Processor Status Register Unit

This block keeps the condition and mode bits of a small 8-bit accumulator processor. The ALU returns new flag values through a per-bit update mask. The instruction decoder issues one-hot set and clear commands for the mode and carry bits through a small command code. The stack logic moves the whole status through two packed byte ports: one to push and one to pull.

From the stored flags the block also works out whether a conditional branch is taken. The branch type is chosen by a 3-bit selector. A break command raises the break flag and a sticky halt output. The halt output stays set until reset.

Inside the block, a control module decodes commands into a strobe struct, and a datapath module holds the flag register, the byte packing and the branch selection.

Top module: `psr_unit`

## Requirements
- R1: After reset, `statusOut` reads 0x20 and `halted` is 0. The byte layout, from bit 0 to bit 7, is: carry, zero, interrupt-disable, decimal, break, unused, overflow, negative.
- R2: `pushData` always equals `statusOut` with bits 4 and 5 forced to 1.
- R3: When `pullEn` is high, the next `statusOut` is `pullData` with bit 4 cleared and bit 5 set.
- R4: A pull in a cycle takes priority over any ALU update and any command in that same cycle.
- R5: For each bit set in `aluMask`, the flag at the same position takes the value of `aluVal` on the next edge. Unmasked flags hold their value. Mask bits 4 and 5 have no effect.
- R6: `flagCmd` codes act on the next edge as follows: 1 clears carry, 2 sets carry, 3 clears decimal, 4 sets decimal, 5 clears interrupt-disable, 6 sets interrupt-disable, 7 clears overflow. Code 0 does nothing.
- R7: Codes 9 to 15 change no flag. No command code sets overflow.
- R8: If an ALU update and a command target the same flag in one cycle, the ALU value is stored.
- R9: `brTaken` is combinational. The selector values are: 0 = negative clear, 1 = negative set, 2 = overflow clear, 3 = overflow set, 4 = carry clear, 5 = carry set, 6 = zero clear, 7 = zero set.
- R10: Code 8 (break) sets bit 4 of `statusOut` and raises `halted`. `halted` stays high until reset, even when a later pull clears bit 4.
- R11: Bit 5 of `statusOut` reads 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flagCmd | input | 4 | Set, clear or break command code |
| aluMask | input | 8 | Per-flag update enable from the ALU |
| aluVal | input | 8 | New flag values from the ALU |
| pullEn | input | 1 | Load the status from `pullData` |
| pullData | input | 8 | Status byte pulled from the stack |
| brSel | input | 3 | Branch type selector |
| statusOut | output | 8 | Stored status byte |
| pushData | output | 8 | Status byte formatted for a push |
| brTaken | output | 1 | Branch condition for `brSel` |
| halted | output | 1 | Sticky halt after a break |

## Verification
The bench pulls 0xFF and 0x00 to check the pull formatting. A design that copied `pullData` unchanged would show bit 4 set or bit 5 clear after the pull.

In single cycles it also:
- makes an ALU update collide with a command on the carry flag, where a wrong priority stores the command's value;
- makes a pull collide with a full ALU update and a command, where a wrong priority leaves flags set.

Reserved codes and mask bits 4 and 5 are applied with overflow already set. This exposes a decoder that aliases a reserved code onto a real command. It also exposes a register that lets the ALU write the break or unused bit.

All eight branch selectors are swept under two flag patterns, which catches swapped polarities or flag pairings. Finally, a pull after a break shows whether the halt output wrongly follows the break bit.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int FLAG_W = 8;
  localparam int CMD_W  = 4;
  localparam int SEL_W  = 3;

  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_I = 2;
  localparam int BIT_D = 3;
  localparam int BIT_B = 4;
  localparam int BIT_U = 5;
  localparam int BIT_V = 6;
  localparam int BIT_N = 7;

  localparam logic [FLAG_W-1:0] MASK_B = FLAG_W'(1) << BIT_B;
  localparam logic [FLAG_W-1:0] MASK_U = FLAG_W'(1) << BIT_U;
  localparam logic [FLAG_W-1:0] ALU_OK = ~(MASK_B | MASK_U);
  localparam logic [FLAG_W-1:0] RST_VAL = MASK_U;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE  = 4'd0,
    CMD_CLR_C = 4'd1,
    CMD_SET_C = 4'd2,
    CMD_CLR_D = 4'd3,
    CMD_SET_D = 4'd4,
    CMD_CLR_I = 4'd5,
    CMD_SET_I = 4'd6,
    CMD_CLR_V = 4'd7,
    CMD_BRK   = 4'd8
  } cmd_e;

  typedef struct packed {
    logic [FLAG_W-1:0] setVec;
    logic [FLAG_W-1:0] clrVec;
  } strobe_t;
endpackage

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CMD_W-1:0] flagCmd,
  output strobe_t          stb,
  output logic             halted
);
  logic haltQ;

  always_comb begin
    stb = '0;
    case (flagCmd)
      CMD_CLR_C: stb.clrVec[BIT_C] = 1'b1;
      CMD_SET_C: stb.setVec[BIT_C] = 1'b1;
      CMD_CLR_D: stb.clrVec[BIT_D] = 1'b1;
      CMD_SET_D: stb.setVec[BIT_D] = 1'b1;
      CMD_CLR_I: stb.clrVec[BIT_I] = 1'b1;
      CMD_SET_I: stb.setVec[BIT_I] = 1'b1;
      CMD_CLR_V: stb.clrVec[BIT_V] = 1'b1;
      CMD_BRK:   stb.setVec[BIT_B] = 1'b1;
      default:   stb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  haltQ <= 1'b0;
    else if (flagCmd == CMD_BRK) haltQ <= 1'b1;
  end

  assign halted = haltQ;

  // R6: at most one flag action per command
  p_one_action_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setVec, stb.clrVec}));

  // R7: overflow is never set by a command
  p_no_set_v_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.setVec[BIT_V]);

  p_brk_halts_r10: assert property (@(posedge clk) disable iff (!rstN)
    (flagCmd == CMD_BRK) |=> halted);

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);
endmodule

// File: rtl/psr_dpath.sv
module psr_dpath
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [FLAG_W-1:0] aluMask,
  input  logic [FLAG_W-1:0] aluVal,
  input  logic              pullEn,
  input  logic [FLAG_W-1:0] pullData,
  input  logic [SEL_W-1:0]  brSel,
  output logic [FLAG_W-1:0] statusOut,
  output logic [FLAG_W-1:0] pushData,
  output logic              brTaken
);
  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] flagD;
  logic [FLAG_W-1:0] pulled;
  logic [FLAG_W-1:0] aluEff;
  logic [3:0]        condVec;

  assign pulled = (pullData & ~MASK_B) | MASK_U;
  assign aluEff = aluMask & ALU_OK;

  // Per-bit priority: pull, then ALU, then set, then clear
  always_comb begin
    for (int i = 0; i < FLAG_W; i++) begin
      if (pullEn)              flagD[i] = pulled[i];
      else if (aluEff[i])      flagD[i] = aluVal[i];
      else if (stb.setVec[i])  flagD[i] = 1'b1;
      else if (stb.clrVec[i])  flagD[i] = 1'b0;
      else                     flagD[i] = flagQ[i];
    end
    flagD[BIT_U] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= RST_VAL;
    else       flagQ <= flagD;
  end

  assign statusOut = flagQ;
  assign pushData  = flagQ | MASK_B | MASK_U;

  // Selector pairs: 0 negative, 1 overflow, 2 carry, 3 zero; bit 0 gives polarity
  assign condVec = {flagQ[BIT_Z], flagQ[BIT_C], flagQ[BIT_V], flagQ[BIT_N]};
  assign brTaken = (condVec[brSel[SEL_W-1:1]] == brSel[0]);

  p_pull_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    pullEn |=> statusOut == (($past(pullData) & 8'hEF) | 8'h20));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!pullEn && aluMask == '0 && stb == '0) |=> $stable(statusOut));

  p_alu_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!pullEn && aluMask[BIT_C]) |=> statusOut[BIT_C] == $past(aluVal[BIT_C]));

  p_brk_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!pullEn && stb.setVec[BIT_B]) |=> statusOut[BIT_B]);

  p_unused_high_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pullEn && !pullData[BIT_U]) |=> statusOut[BIT_U]);
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CMD_W-1:0]  flagCmd,
  input  logic [FLAG_W-1:0] aluMask,
  input  logic [FLAG_W-1:0] aluVal,
  input  logic              pullEn,
  input  logic [FLAG_W-1:0] pullData,
  input  logic [SEL_W-1:0]  brSel,
  output logic [FLAG_W-1:0] statusOut,
  output logic [FLAG_W-1:0] pushData,
  output logic              brTaken,
  output logic              halted
);
  strobe_t stb;

  psr_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .flagCmd (flagCmd),
    .stb     (stb),
    .halted  (halted)
  );

  psr_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .aluMask   (aluMask),
    .aluVal    (aluVal),
    .pullEn    (pullEn),
    .pullData  (pullData),
    .brSel     (brSel),
    .statusOut (statusOut),
    .pushData  (pushData),
    .brTaken   (brTaken)
  );
endmodule

// File: tb/psr_unit_tb.sv
module psr_unit_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] flagCmd = '0;
  logic [7:0] aluMask = '0;
  logic [7:0] aluVal = '0;
  logic       pullEn = 1'b0;
  logic [7:0] pullData = '0;
  logic [2:0] brSel = '0;
  logic [7:0] statusOut, pushData;
  logic       brTaken, halted;
  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  psr_unit u_dut (
    .clk(clk), .rstN(rstN), .flagCmd(flagCmd), .aluMask(aluMask),
    .aluVal(aluVal), .pullEn(pullEn), .pullData(pullData), .brSel(brSel),
    .statusOut(statusOut), .pushData(pushData), .brTaken(brTaken),
    .halted(halted)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    flagCmd = '0; aluMask = '0; aluVal = '0; pullEn = 1'b0; pullData = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic cmd(input logic [3:0] c);
    flagCmd = c; tick(); idle();
  endtask

  task automatic pull(input logic [7:0] d);
    pullEn = 1'b1; pullData = d; tick(); idle();
  endtask

  function automatic logic expBranch(input logic [7:0] f, input logic [2:0] s);
    logic v;
    case (s[2:1])
      2'd0: v = f[7];
      2'd1: v = f[6];
      2'd2: v = f[0];
      default: v = f[1];
    endcase
    return v == s[0];
  endfunction

  task automatic t_reset();
    doReset();
    chk("R1 status", statusOut, 8'h20);
    chk("R1 halted", {7'd0, halted}, 8'h00);
    chk("R2 push", pushData, 8'h30);
    chk("R11 unused", {7'd0, statusOut[5]}, 8'h01);
  endtask

  task automatic t_cmds();
    doReset();
    cmd(4'd2); chk("R6 set C", statusOut, 8'h21);
    cmd(4'd4); chk("R6 set D", statusOut, 8'h29);
    cmd(4'd6); chk("R6 set I", statusOut, 8'h2D);
    chk("R2 push", pushData, 8'h3D);
    cmd(4'd5); chk("R6 clr I", statusOut, 8'h29);
    cmd(4'd3); chk("R6 clr D", statusOut, 8'h21);
    cmd(4'd1); chk("R6 clr C", statusOut, 8'h20);
    aluMask = 8'h40; aluVal = 8'h40; tick(); idle();
    chk("R5 set V by alu", statusOut, 8'h60);
    for (int c = 9; c < 16; c++) begin
      cmd(4'(c));
      chk("R7 reserved code", statusOut, 8'h60);
    end
    cmd(4'd0); chk("R6 none", statusOut, 8'h60);
    cmd(4'd7); chk("R6 clr V", statusOut, 8'h20);
  endtask

  task automatic t_alu();
    doReset();
    aluMask = 8'hC3; aluVal = 8'hFF; tick(); idle();
    chk("R5 masked update", statusOut, 8'hE3);
    aluMask = 8'h30; aluVal = 8'h00; tick(); idle();
    chk("R5 bits 4/5 ignored", statusOut, 8'hE3);
    aluMask = 8'h02; aluVal = 8'h00; tick(); idle();
    chk("R5 single bit", statusOut, 8'hE1);
    aluMask = 8'h01; aluVal = 8'h01; flagCmd = 4'd1; tick(); idle();
    chk("R8 alu beats clear", statusOut, 8'hE1);
    aluMask = 8'h01; aluVal = 8'h00; flagCmd = 4'd2; tick(); idle();
    chk("R8 alu beats set", statusOut, 8'hE0);
  endtask

  task automatic t_pull();
    doReset();
    pull(8'hFF);
    chk("R3 pull FF", statusOut, 8'hEF);
    chk("R2 push after pull", pushData, 8'hFF);
    pull(8'h00);
    chk("R3 pull 00", statusOut, 8'h20);
    pull(8'hFF);
    pullEn = 1'b1; pullData = 8'h00; aluMask = 8'hFF; aluVal = 8'hFF; flagCmd = 4'd2;
    tick(); idle();
    chk("R4 pull priority", statusOut, 8'h20);
  endtask

  task automatic t_branch();
    logic [7:0] pats [2] = '{8'h81, 8'h42};
    doReset();
    foreach (pats[p]) begin
      pull(pats[p]);
      for (int s = 0; s < 8; s++) begin
        brSel = 3'(s);
        #1;
        chk("R9 branch", {7'd0, brTaken}, {7'd0, expBranch(pats[p] | 8'h20, 3'(s))});
      end
    end
  endtask

  task automatic t_break();
    doReset();
    cmd(4'd8);
    chk("R10 break flag", statusOut, 8'h30);
    chk("R10 halted", {7'd0, halted}, 8'h01);
    tick(); tick();
    chk("R10 halt sticky", {7'd0, halted}, 8'h01);
    pull(8'h10);
    chk("R10 pull clears B", statusOut, 8'h20);
    chk("R10 halt survives pull", {7'd0, halted}, 8'h01);
    doReset();
    chk("R1 halt cleared by reset", {7'd0, halted}, 8'h00);
  endtask

  initial begin
    #(200000 * 8);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    t_reset();
    t_cmds();
    t_alu();
    t_pull();
    t_branch();
    t_break();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule